// File: doc/BRIEF.md
# General-Purpose I/O Port Data Register

This block is a small memory-mapped general-purpose I/O port of up to eight pins. It sits on a simple register bus with byte enables and presents two 16-bit registers. The data register can be read and written. The port register is read-only and shows the pin levels. An external function-select block supplies a per-pin mode bit (`1` = general output, `0` = general input). The block drives output pins from the stored data bits and enables their output drivers. Input pins are left tri-stated.

A read of the data register is resolved per bit. An output pin returns its stored bit whatever level the pin has. An input pin returns its sampled pin level. A write to an input pin is still stored, and that value drives the pin once the pin is switched to output. Pin inputs go through a two-flop synchronizer before they reach either read path. A build parameter selects the variant with pins 2 to 7 only, where bits 0 and 1 are absent.

Top module: `gpio_port_regs`

## Requirements
- R1: After synchronous reset, the stored data bits, `pin_out`, `pin_oe` and `bus_rdata` are all zero.
- R2: A write to the data register (byte offset 0x02, `bus_be[0]` set) updates `pin_out` on the clock edge that accepts the write. A later read of the data register returns the stored bit for every pin whose mode bit is 1, whatever the level on `pin_in`.
- R3: For a pin whose mode bit is 0, a read of the data register returns the synchronized pin level, not the stored bit. This is resolved per bit when modes are mixed.
- R4: A write to a pin in input mode is stored but leaves `pin_oe` low. Once the mode bit goes to 1, the pin drives the stored value and reads return it.
- R5: `pin_oe` equals the mode input of implemented pins, registered one clock later.
- R6: The port register (byte offset 0x1E) returns the synchronized pin levels in bits 7:0 in every mode and zero in bits 15:8. Writes to it change nothing.
- R7: Byte lane 0 (`bus_be[0]`) writes bits 7:0 of the data register. A write on lane 1 alone is ignored, and bits 15:8 of the data register always read zero.
- R8: With `LOW_PIN`=2, bits 0 and 1 are unimplemented. They read zero in both registers and never drive `pin_out` or `pin_oe`.
- R9: A read of any other offset returns zero, and a write to one changes no state.
- R10: A pin change reaches the read path only after two clock edges. A read accepted at the edge right after the change, or at the following edge, returns the old level. The read after that returns the new level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset inside the port block |
| bus_be | input | 2 | Byte enables: bit 0 = bits 7:0, bit 1 = bits 15:8 |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, registered; zero when no read |
| mode_out | input | NUM_PINS | Per-pin mode: 1 = general output, 0 = general input |
| pin_in | input | NUM_PINS | Asynchronous pin levels |
| pin_out | output | NUM_PINS | Pin drive values |
| pin_oe | output | NUM_PINS | Pin output enables |

## Verification
Each result has its own fixed delay. `pin_out` follows a write at the edge that accepts the write. `pin_oe` follows a mode change one edge later. `bus_rdata` holds the read result after the edge that accepts the read. A pin change needs two edges in the synchronizer before a read edge can see it. The bench drives every input on a falling edge and samples one falling edge later, so each check falls exactly in the cycle where its result is due. The synchronizer test issues back-to-back reads from the cycle of the pin change to show the two old values and then the new one.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_DATA = 2'd1,
    SEL_PORT = 2'd2
  } reg_sel_e;

  localparam int unsigned DATA_REG_OFF = 32'h02;
  localparam int unsigned PORT_REG_OFF = 32'h1E;
  localparam int unsigned REG_W        = 16;
  localparam int unsigned LANE_W       = 8;

  // Bit i is set when pin i exists in the build.
  function automatic logic [31:0] impl_mask(int unsigned num_pins, int unsigned low_pin);
    logic [31:0] m;
    m = '0;
    for (int unsigned i = 0; i < 32; i++) begin
      m[i] = (i >= low_pin) && (i < num_pins);
    end
    return m;
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_data_store.sv
module gpio_data_store #(
  parameter int unsigned W        = 8,
  parameter logic [W-1:0] IMPL    = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] bit_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);

  for (genvar b = 0; b < W; b++) begin : g_bit
    if (IMPL[b]) begin : g_impl
      logic bit_q;
      always_ff @(posedge clk) begin
        if (rst)            bit_q <= 1'b0;
        else if (bit_we[b]) bit_q <= wdata[b];
      end
      assign q[b] = bit_q;
    end else begin : g_absent
      logic unused_b;
      assign unused_b = bit_we[b] ^ wdata[b];
      assign q[b]     = 1'b0;
    end
  end

endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
  import gpio_port_pkg::*;
#(
  parameter int unsigned W     = 8,
  parameter int unsigned OUT_W = 16,
  parameter logic [W-1:0] IMPL = '1
) (
  input  reg_sel_e         sel,
  input  logic [W-1:0]     mode,
  input  logic [W-1:0]     data_q,
  input  logic [W-1:0]     pins_sync,
  output logic [OUT_W-1:0] rd
);

  always_comb begin
    rd = '0;
    unique case (sel)
      SEL_DATA: rd[W-1:0] = ((mode & data_q) | (~mode & pins_sync)) & IMPL;
      SEL_PORT: rd[W-1:0] = pins_sync & IMPL;
      default:  rd = '0;
    endcase
  end

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 8,
  parameter int unsigned LOW_PIN     = 0,
  parameter int unsigned ADDR_W      = 5,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DATA_OFF    = DATA_REG_OFF,
  parameter int unsigned PORT_OFF    = PORT_REG_OFF
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [1:0]          bus_be,
  input  logic [15:0]         bus_wdata,
  output logic [15:0]         bus_rdata,
  input  logic [NUM_PINS-1:0] mode_out,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe
);

  localparam logic [NUM_PINS-1:0] IMPL    = NUM_PINS'(impl_mask(NUM_PINS, LOW_PIN));
  localparam logic [ADDR_W-2:0]   DATA_HW = (ADDR_W-1)'(DATA_OFF / 2);
  localparam logic [ADDR_W-2:0]   PORT_HW = (ADDR_W-1)'(PORT_OFF / 2);

  reg_sel_e            sel_c;
  logic [NUM_PINS-1:0] bit_we;
  logic [NUM_PINS-1:0] data_q;
  logic [NUM_PINS-1:0] pins_sync;
  logic [REG_W-1:0]    rd_c;
  logic                unused_ok;

  // Halfword-aligned decode; byte lanes come from bus_be.
  always_comb begin
    if (bus_addr[ADDR_W-1:1] == DATA_HW)      sel_c = SEL_DATA;
    else if (bus_addr[ADDR_W-1:1] == PORT_HW) sel_c = SEL_PORT;
    else                                      sel_c = SEL_NONE;
  end

  for (genvar b = 0; b < NUM_PINS; b++) begin : g_we
    assign bit_we[b] = bus_sel && bus_wr && (sel_c == SEL_DATA) && bus_be[b / LANE_W];
  end

  gpio_data_store #(
    .W    (NUM_PINS),
    .IMPL (IMPL)
  ) i_store (
    .clk    (clk),
    .rst    (rst),
    .bit_we (bit_we),
    .wdata  (bus_wdata[NUM_PINS-1:0]),
    .q      (data_q)
  );

  gpio_sync #(
    .W      (NUM_PINS),
    .STAGES (SYNC_STAGES)
  ) i_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_in & IMPL),
    .q   (pins_sync)
  );

  gpio_read_mux #(
    .W     (NUM_PINS),
    .OUT_W (REG_W),
    .IMPL  (IMPL)
  ) i_rmux (
    .sel       (sel_c),
    .mode      (mode_out),
    .data_q    (data_q),
    .pins_sync (pins_sync),
    .rd        (rd_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      pin_oe    <= '0;
    end else begin
      bus_rdata <= (bus_sel && !bus_wr) ? rd_c : '0;
      pin_oe    <= mode_out & IMPL;
    end
  end

  assign pin_out   = data_q;
  assign unused_ok = ^{bus_wdata, bus_be, bus_addr[0]};

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
  import gpio_port_pkg::*;
#(
  parameter int unsigned NUM_PINS = 8,
  parameter int unsigned LOW_PIN  = 0,
  parameter int unsigned ADDR_W   = 5,
  parameter int unsigned DATA_OFF = DATA_REG_OFF,
  parameter int unsigned PORT_OFF = PORT_REG_OFF
) (
  input logic                clk,
  input logic                rst,
  input logic                bus_sel,
  input logic                bus_wr,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [1:0]          bus_be,
  input logic [15:0]         bus_wdata,
  input logic [15:0]         bus_rdata,
  input logic [NUM_PINS-1:0] mode_out,
  input logic [NUM_PINS-1:0] pin_out,
  input logic [NUM_PINS-1:0] pin_oe
);

  localparam logic [NUM_PINS-1:0] IMPL    = NUM_PINS'(impl_mask(NUM_PINS, LOW_PIN));
  localparam logic [ADDR_W-2:0]   DATA_HW = (ADDR_W-1)'(DATA_OFF / 2);
  localparam logic [ADDR_W-2:0]   PORT_HW = (ADDR_W-1)'(PORT_OFF / 2);

  logic hit_data, hit_port;
  assign hit_data = bus_addr[ADDR_W-1:1] == DATA_HW;
  assign hit_port = bus_addr[ADDR_W-1:1] == PORT_HW;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (pin_out == '0 && pin_oe == '0 && bus_rdata == '0));

  // R2
  write_drives_pin_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_wr && hit_data && bus_be[0])
      |=> pin_out == ($past(bus_wdata[NUM_PINS-1:0]) & IMPL));

  // R5
  oe_follows_mode_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> pin_oe == ($past(mode_out) & IMPL));

  // R6
  port_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_wr && hit_port) |=> bus_rdata[15:8] == 8'h00);

  // R7
  data_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_wr && hit_data) |=> bus_rdata[15:8] == 8'h00);

  // R8
  absent_bits_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ((pin_out | pin_oe | bus_rdata[NUM_PINS-1:0]) & ~IMPL) == '0);

  // R9
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_wr && !hit_data && !hit_port) |=> bus_rdata == 16'h0000);

endmodule

bind gpio_port_regs gpio_port_chk #(
  .NUM_PINS (NUM_PINS),
  .LOW_PIN  (LOW_PIN),
  .ADDR_W   (ADDR_W),
  .DATA_OFF (DATA_OFF),
  .PORT_OFF (PORT_OFF)
) i_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_be    (bus_be),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .mode_out  (mode_out),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe)
);

// File: tb/test_gpio_port_regs.sv
`timescale 1ns/1ps
module test_gpio_port_regs;

  localparam logic [4:0] A_DATA = 5'h02;
  localparam logic [4:0] A_PORT = 5'h1E;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [1:0]  bus_be = '0;
  logic [15:0] bus_wdata = '0;
  logic [7:0]  mode_out = '0;
  logic [7:0]  pin_in = '0;
  logic [15:0] bus_rdata, rdata_lo;
  logic [7:0]  pin_out, pin_oe, pin_out_lo, pin_oe_lo;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  gpio_port_regs i_gpio_port_regs (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .mode_out(mode_out), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  gpio_port_regs #(.LOW_PIN(2)) i_gpio_port_regs_lo (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(rdata_lo),
    .mode_out(mode_out), .pin_in(pin_in), .pin_out(pin_out_lo), .pin_oe(pin_oe_lo)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // All tasks start and end on a falling edge.
  task automatic bus_write(logic [4:0] a, logic [1:0] be, logic [15:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_be = '0;
  endtask

  task automatic bus_read(logic [4:0] a, output logic [15:0] d, output logic [15:0] d_lo);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_be = 2'b11;
    @(negedge clk);
    d = bus_rdata; d_lo = rdata_lo;
    bus_sel = 1'b0; bus_be = '0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] d, dl;
    check("R1 pin_out", {8'h0, pin_out}, 16'h0000);
    check("R1 pin_oe", {8'h0, pin_oe}, 16'h0000);
    check("R1 rdata", bus_rdata, 16'h0000);
    mode_out = 8'hFF; settle();
    bus_read(A_DATA, d, dl);
    check("R1 data reg", d, 16'h0000);
  endtask

  task automatic t_output();
    logic [15:0] d, dl;
    mode_out = 8'hFF; pin_in = 8'h00; settle();
    check("R5 oe all out", {8'h0, pin_oe}, 16'h00FF);
    bus_write(A_DATA, 2'b01, 16'h00A5);
    check("R2 pin_out after write", {8'h0, pin_out}, 16'h00A5);
    bus_read(A_DATA, d, dl);
    check("R2 read stored not pin", d, 16'h00A5);
  endtask

  task automatic t_input();
    logic [15:0] d, dl;
    mode_out = 8'h00; pin_in = 8'h3C; settle();
    check("R5 oe all in", {8'h0, pin_oe}, 16'h0000);
    bus_read(A_DATA, d, dl);
    check("R3 read pins", d, 16'h003C);
    mode_out = 8'hF0; pin_in = 8'h0F; settle();
    bus_read(A_DATA, d, dl);
    check("R3 mixed modes", d, 16'h00AF);
  endtask

  task automatic t_input_store();
    logic [15:0] d, dl;
    mode_out = 8'h00; pin_in = 8'h11; settle();
    bus_write(A_DATA, 2'b01, 16'h005A);
    check("R4 oe stays low", {8'h0, pin_oe}, 16'h0000);
    bus_read(A_DATA, d, dl);
    check("R4 input read shows pins", d, 16'h0011);
    mode_out = 8'hFF;
    @(negedge clk);
    check("R4 oe after switch", {8'h0, pin_oe}, 16'h00FF);
    check("R4 pin drives stored", {8'h0, pin_out}, 16'h005A);
    bus_read(A_DATA, d, dl);
    check("R4 read stored after switch", d, 16'h005A);
  endtask

  task automatic t_sync();
    logic [15:0] d, dl;
    mode_out = 8'h00; pin_in = 8'h00; settle();
    pin_in = 8'hFF;
    bus_read(A_PORT, d, dl);
    check("R10 first read old", d, 16'h0000);
    bus_read(A_PORT, d, dl);
    check("R10 second read old", d, 16'h0000);
    bus_read(A_PORT, d, dl);
    check("R10 third read new", d, 16'h00FF);
  endtask

  task automatic t_port();
    logic [15:0] d, dl;
    mode_out = 8'hFF; pin_in = 8'h96; settle();
    bus_read(A_PORT, d, dl);
    check("R6 port shows pins in output mode", d, 16'h0096);
    bus_write(A_PORT, 2'b11, 16'hFFFF);
    check("R6 port write no pin change", {8'h0, pin_out}, 16'h005A);
    bus_read(A_DATA, d, dl);
    check("R6 port write leaves data", d, 16'h005A);
    bus_read(A_PORT, d, dl);
    check("R6 port unchanged", d, 16'h0096);
  endtask

  task automatic t_bytes();
    logic [15:0] d, dl;
    mode_out = 8'hFF; settle();
    bus_write(A_DATA, 2'b10, 16'h1234);
    check("R7 upper lane ignored pin", {8'h0, pin_out}, 16'h005A);
    bus_read(A_DATA, d, dl);
    check("R7 upper lane ignored read", d, 16'h005A);
    bus_write(A_DATA, 2'b11, 16'hBEEF);
    bus_read(A_DATA, d, dl);
    check("R7 halfword write keeps low byte only", d, 16'h00EF);
  endtask

  task automatic t_unmapped();
    logic [15:0] d, dl;
    bus_read(5'h00, d, dl);
    check("R9 offset 0 reads zero", d, 16'h0000);
    bus_read(5'h10, d, dl);
    check("R9 offset 0x10 reads zero", d, 16'h0000);
    bus_write(5'h00, 2'b11, 16'h0000);
    check("R9 write elsewhere pin", {8'h0, pin_out}, 16'h00EF);
    bus_read(A_DATA, d, dl);
    check("R9 write elsewhere data", d, 16'h00EF);
  endtask

  task automatic t_variant();
    logic [15:0] d, dl;
    mode_out = 8'hFF; settle();
    bus_write(A_DATA, 2'b01, 16'h00FF);
    @(negedge clk);
    check("R8 low variant pin_out", {8'h0, pin_out_lo}, 16'h00FC);
    check("R8 low variant pin_oe", {8'h0, pin_oe_lo}, 16'h00FC);
    bus_read(A_DATA, d, dl);
    check("R8 low variant data read", dl, 16'h00FC);
    check("R8 full variant data read", d, 16'h00FF);
    mode_out = 8'h00; pin_in = 8'hFF; settle();
    bus_read(A_PORT, d, dl);
    check("R8 low variant port read", dl, 16'h00FC);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_output();
    t_input();
    t_input_store();
    t_sync();
    t_port();
    t_bytes();
    t_unmapped();
    t_variant();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule